// File: doc/BRIEF.md
# Eight-Cell Configurable Logic Block

This block is a behavioural, synthesizable model of one programmable logic block. The block holds eight logic cells. Each cell has a 4-input lookup table, a carry unit and an optional output flip-flop. Each cell takes a 20-bit configuration word and four data inputs. It also takes two extra per-cell selects: one puts the incoming carry on LUT input 3, and one puts the previous cell's LUT result on LUT input 2. These selects let a ripple adder or a cascaded function be built without outside routing.

The eight cells share the clock, clock enable, set/reset, a falling-edge select and a carry-in source select. The outputs are the eight cell results and the carry leaving the last cell. That carry can feed the carry-in of a neighbouring block.

Top module: `plb_octet`

## Requirements
- R1: A cell's LUT result for the 4-bit index {in3,in2,in1,in0} = k (k = 0..15) is configuration bit P[k], where P = 4,14,15,5,6,16,17,7,3,13,12,2,1,11,10,0. `cell_din[i]` bit 3..0 carries in3..in0.
- R2: When configuration bit 9 is clear, `cell_out[i]` follows the LUT result combinationally, with no clock edge needed.
- R3: When configuration bit 8 is set, the carry out of a cell is the majority of in1, the effective in2 and that cell's carry in. When bit 8 is clear, the carry out of that cell is 0.
- R4: Cell 0's carry in comes from `cin_sel`. Code 0 gives constant 0, code 1 gives constant 1, code 2 gives `cin_ext`, and code 3 gives 0. Cell i>0 takes the carry out of cell i-1.
- R5: When `carry_sub[i]` is set, LUT input in3 of cell i is replaced by that cell's carry in. For cell 0 this is the value chosen by `cin_sel`.
- R6: When `cascade_sub[i]` is set for i>0, LUT input in2 of cell i is replaced by the LUT result of cell i-1. `cascade_sub[0]` has no effect.
- R7: When configuration bit 9 is set, `cell_out[i]` shows a flip-flop. The flip-flop loads the LUT result on an active clock edge only while `ce` is 1, and otherwise holds.
- R8: When bit 19 is clear, `sr` acts on the active edge and takes priority over `ce`. It loads 1 if bit 18 is set and 0 if bit 18 is clear.
- R9: When bit 19 is set, a high `sr` forces the flip-flop to the bit-18 value at once, without waiting for a clock edge.
- R10: When `neg_edge` is 1, all eight flip-flops update on the falling clock edge and ignore the rising edge.
- R11: When `rst` is high, all flip-flops clear to 0 on the active edge. This takes priority over `ce` and over a synchronous `sr`.
- R12: `cout_top` equals the carry out of the last cell, so eight cells in adder form produce an 8-bit sum with carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset of all flip-flops |
| cell_cfg | input | 8x20 | Per-cell configuration words |
| carry_sub | input | 8 | Per-cell select: carry in replaces in3 |
| cascade_sub | input | 8 | Per-cell select: previous LUT result replaces in2 |
| neg_edge | input | 1 | Shared falling-edge select |
| cin_sel | input | 2 | Carry-in source code for cell 0 |
| cin_ext | input | 1 | Carry from the neighbouring block |
| ce | input | 1 | Shared clock enable |
| sr | input | 1 | Shared set/reset |
| cell_din | input | 8x4 | Per-cell LUT inputs {in3,in2,in1,in0} |
| cell_out | output | 8 | Cell results |
| cout_top | output | 1 | Carry out of the last cell |

## Verification
The bench writes LUT contents through the permuted bit table and compares them with a linear truth table. A model that read the configuration bits in plain binary order would give wrong results for almost every random word. The adder runs cover carries through all eight cells and every carry-in code, including the reserved code 3. A chain that ignored the carry enable or took the wrong carry-in source would give a wrong sum or a wrong `cout_top`. The flip-flop scenarios test each timing case separately:
- A design that applied set/reset asynchronously in synchronous mode would change the output before the edge.
- A design that waited for a clock edge in asynchronous mode would change it too late.
- A design that let the wrong clock edge load the flop would capture data on the rising edge in falling-edge mode.
- A design that let cascade substitution act on cell 0 would flip that cell's result.

// File: rtl/plb_pkg.sv
`timescale 1ns/1ps
package plb_pkg;

    localparam int LUT_K        = 4;
    localparam int LUT_ROWS     = 1 << LUT_K;
    localparam int CFG_W        = 20;
    localparam int CFG_IDX_W    = $clog2(CFG_W);

    localparam int BIT_CARRY_EN = 8;
    localparam int BIT_REG_EN   = 9;
    localparam int BIT_SET      = 18;
    localparam int BIT_ASYNC    = 19;

    typedef logic [CFG_W-1:0] cell_cfg_t;
    typedef logic [LUT_K-1:0] lut_idx_t;

    typedef enum logic [1:0] {
        CIN_ZERO  = 2'd0,
        CIN_ONE   = 2'd1,
        CIN_CHAIN = 2'd2,
        CIN_RSVD  = 2'd3
    } cin_src_e;

    typedef struct packed {
        logic reg_en;
        logic set_val;
        logic async_sr;
    } ff_mode_t;

    // Position of the truth-table entry for a given input index.
    function automatic logic [CFG_IDX_W-1:0] lut_cfg_pos(input lut_idx_t idx);
        logic [CFG_IDX_W-1:0] p;
        case (idx)
            4'd0:    p = 5'd4;
            4'd1:    p = 5'd14;
            4'd2:    p = 5'd15;
            4'd3:    p = 5'd5;
            4'd4:    p = 5'd6;
            4'd5:    p = 5'd16;
            4'd6:    p = 5'd17;
            4'd7:    p = 5'd7;
            4'd8:    p = 5'd3;
            4'd9:    p = 5'd13;
            4'd10:   p = 5'd12;
            4'd11:   p = 5'd2;
            4'd12:   p = 5'd1;
            4'd13:   p = 5'd11;
            4'd14:   p = 5'd10;
            default: p = 5'd0;
        endcase
        return p;
    endfunction

    function automatic logic lut_eval(input cell_cfg_t cfg, input lut_idx_t idx);
        return cfg[lut_cfg_pos(idx)];
    endfunction

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic ff_mode_t ff_mode(input cell_cfg_t cfg);
        ff_mode_t m;
        m.reg_en   = cfg[BIT_REG_EN];
        m.set_val  = cfg[BIT_SET];
        m.async_sr = cfg[BIT_ASYNC];
        return m;
    endfunction

endpackage

// File: rtl/plb_cin_sel.sv
`timescale 1ns/1ps
module plb_cin_sel (
    input  plb_pkg::cin_src_e sel,
    input  logic              ext_carry,
    output logic              cin
);
    always_comb begin
        unique case (sel)
            plb_pkg::CIN_ONE:   cin = 1'b1;
            plb_pkg::CIN_CHAIN: cin = ext_carry;
            default:            cin = 1'b0;
        endcase
    end
endmodule

// File: rtl/plb_chain.sv
`timescale 1ns/1ps
module plb_chain #(
    parameter int NUM_CELLS = 8
) (
    input  plb_pkg::cell_cfg_t [NUM_CELLS-1:0] cfg,
    input  plb_pkg::lut_idx_t  [NUM_CELLS-1:0] din,
    input  logic [NUM_CELLS-1:0]               carry_sub,
    input  logic [NUM_CELLS-1:0]               cascade_sub,
    input  logic                               cin,
    output logic [NUM_CELLS-1:0]               lut_o,
    output logic [NUM_CELLS-1:0]               cout
);
    import plb_pkg::*;

    // One ordered pass keeps the ripple acyclic for every cell count.
    always_comb begin
        logic     c_prev;
        logic     l_prev;
        lut_idx_t idx;
        c_prev = cin;
        l_prev = 1'b0;
        lut_o  = '0;
        cout   = '0;
        for (int i = 0; i < NUM_CELLS; i++) begin
            idx = din[i];
            if (carry_sub[i])
                idx[3] = c_prev;
            if ((i > 0) && cascade_sub[i])
                idx[2] = l_prev;
            lut_o[i] = lut_eval(cfg[i], idx);
            cout[i]  = cfg[i][BIT_CARRY_EN] & maj3(idx[1], idx[2], c_prev);
            c_prev   = cout[i];
            l_prev   = lut_o[i];
        end
    end
endmodule

// File: rtl/plb_cell_ff.sv
`timescale 1ns/1ps
module plb_cell_ff (
    input  logic              clk_act,
    input  logic              rst,
    input  logic              d,
    input  logic              ce,
    input  logic              sr,
    input  plb_pkg::ff_mode_t mode,
    output logic              q
);
    logic async_hit;
    assign async_hit = sr & mode.async_sr;

    always_ff @(posedge clk_act or posedge async_hit) begin
        if (async_hit)
            q <= mode.set_val;
        else if (rst)
            q <= 1'b0;
        else if (sr)
            q <= mode.set_val;
        else if (ce)
            q <= d;
    end
endmodule

// File: rtl/plb_octet.sv
`timescale 1ns/1ps
module plb_octet #(
    parameter int NUM_CELLS = 8
) (
    input  logic                                        clk,
    input  logic                                        rst,
    input  logic [NUM_CELLS-1:0][plb_pkg::CFG_W-1:0]    cell_cfg,
    input  logic [NUM_CELLS-1:0]                        carry_sub,
    input  logic [NUM_CELLS-1:0]                        cascade_sub,
    input  logic                                        neg_edge,
    input  logic [1:0]                                  cin_sel,
    input  logic                                        cin_ext,
    input  logic                                        ce,
    input  logic                                        sr,
    input  logic [NUM_CELLS-1:0][plb_pkg::LUT_K-1:0]    cell_din,
    output logic [NUM_CELLS-1:0]                        cell_out,
    output logic                                        cout_top
);
    import plb_pkg::*;

    logic                 clk_act;
    logic                 cin0;
    logic [NUM_CELLS-1:0] lut_o;
    logic [NUM_CELLS-1:0] cout;
    logic [NUM_CELLS-1:0] q;

    // Shared polarity: inverting the clock moves every flop to the falling edge.
    assign clk_act = clk ^ neg_edge;

    plb_cin_sel u_cin (
        .sel       (cin_src_e'(cin_sel)),
        .ext_carry (cin_ext),
        .cin       (cin0)
    );

    plb_chain #(.NUM_CELLS(NUM_CELLS)) u_chain (
        .cfg         (cell_cfg),
        .din         (cell_din),
        .carry_sub   (carry_sub),
        .cascade_sub (cascade_sub),
        .cin         (cin0),
        .lut_o       (lut_o),
        .cout        (cout)
    );

    for (genvar g = 0; g < NUM_CELLS; g++) begin : g_cell
        plb_cell_ff u_ff (
            .clk_act (clk_act),
            .rst     (rst),
            .d       (lut_o[g]),
            .ce      (ce),
            .sr      (sr),
            .mode    (ff_mode(cell_cfg[g])),
            .q       (q[g])
        );
        assign cell_out[g] = cell_cfg[g][BIT_REG_EN] ? q[g] : lut_o[g];
    end

    assign cout_top = cout[NUM_CELLS-1];
endmodule

// File: rtl/plb_octet_chk.sv
`timescale 1ns/1ps
module plb_octet_chk #(
    parameter int NUM_CELLS = 8
) (
    input  logic                                     clk,
    input  logic                                     rst,
    input  logic [NUM_CELLS-1:0][plb_pkg::CFG_W-1:0] cell_cfg,
    input  logic                                     neg_edge,
    input  logic                                     ce,
    input  logic                                     sr,
    input  logic [NUM_CELLS-1:0]                     cell_out,
    input  logic                                     cout_top
);
    import plb_pkg::*;

    AST_CARRY_OFF: assert property (@(posedge clk) disable iff (rst)
        !cell_cfg[NUM_CELLS-1][BIT_CARRY_EN] |-> !cout_top)
        else $error("last cell carry high with carry disabled"); // R3

    for (genvar i = 0; i < NUM_CELLS; i++) begin : g_chk
        AST_ASYNC_FORCE: assert property (@(posedge clk) disable iff (rst)
            (sr && cell_cfg[i][BIT_ASYNC] && cell_cfg[i][BIT_REG_EN])
            |-> (cell_out[i] == cell_cfg[i][BIT_SET]))
            else $error("async set/reset not forcing cell %0d", i); // R9

        AST_HOLD_NO_CE: assert property (@(posedge clk) disable iff (rst)
            ($past(!ce && !sr && !rst && !neg_edge && cell_cfg[i][BIT_REG_EN])
             && !sr && !neg_edge && $stable(cell_cfg[i]))
            |-> $stable(cell_out[i]))
            else $error("registered cell %0d changed without enable", i); // R7

        AST_SYNC_SR: assert property (@(posedge clk) disable iff (rst)
            ($past(sr && !rst && !neg_edge && cell_cfg[i][BIT_REG_EN]
                   && !cell_cfg[i][BIT_ASYNC])
             && !neg_edge && $stable(cell_cfg[i]))
            |-> (cell_out[i] == $past(cell_cfg[i][BIT_SET])))
            else $error("sync set/reset wrong on cell %0d", i); // R8
    end
endmodule

bind plb_octet plb_octet_chk #(.NUM_CELLS(NUM_CELLS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cell_cfg (cell_cfg),
    .neg_edge (neg_edge),
    .ce       (ce),
    .sr       (sr),
    .cell_out (cell_out),
    .cout_top (cout_top)
);

// File: tb/plb_octet_bench.sv
`timescale 1ns/1ps
module plb_octet_bench;
    localparam int N = 8;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [N-1:0][19:0]  cell_cfg = '0;
    logic [N-1:0]        carry_sub = '0;
    logic [N-1:0]        cascade_sub = '0;
    logic                neg_edge = 1'b0;
    logic [1:0]          cin_sel = 2'd0;
    logic                cin_ext = 1'b0;
    logic                ce = 1'b0;
    logic                sr = 1'b0;
    logic [N-1:0][3:0]   cell_din = '0;
    logic [N-1:0]        cell_out;
    logic                cout_top;

    int checks = 0;
    int errs   = 0;
    bit done   = 0;

    int perm [16] = '{4, 14, 15, 5, 6, 16, 17, 7, 3, 13, 12, 2, 1, 11, 10, 0};

    always #2.5 clk = ~clk;

    plb_octet #(.NUM_CELLS(N)) u_plb_octet (
        .clk(clk), .rst(rst), .cell_cfg(cell_cfg), .carry_sub(carry_sub),
        .cascade_sub(cascade_sub), .neg_edge(neg_edge), .cin_sel(cin_sel),
        .cin_ext(cin_ext), .ce(ce), .sr(sr), .cell_din(cell_din),
        .cell_out(cell_out), .cout_top(cout_top)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Place a linear truth table into the permuted configuration bits.
    function automatic logic [19:0] mk_cfg(input logic [15:0] truth, input bit carry_en,
                                           input bit reg_en, input bit set_v, input bit async_v);
        logic [19:0] c = '0;
        for (int k = 0; k < 16; k++) c[perm[k]] = truth[k];
        c[8]  = carry_en;
        c[9]  = reg_en;
        c[18] = set_v;
        c[19] = async_v;
        return c;
    endfunction

    function automatic logic [15:0] sum_truth();
        logic [15:0] t;
        for (int k = 0; k < 16; k++) t[k] = k[1] ^ k[2] ^ k[3];
        return t;
    endfunction

    task automatic set_bit0(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) cell_din[i] = {3'b000, v[i]};
    endtask

    task automatic all_cfg(input logic [19:0] c);
        for (int i = 0; i < N; i++) cell_cfg[i] = c;
    endtask

    task automatic t_reset_state();
        all_cfg(mk_cfg(16'hAAAA, 0, 1, 0, 0));
        rst = 1'b1;
        step(); step();
        #0.5;
        check("R11 reset state", cell_out, 0);
        rst = 1'b0;
    endtask

    task automatic t_lut_random();
        for (int it = 0; it < 24; it++) begin
            logic [N-1:0] exp;
            for (int i = 0; i < N; i++) begin
                cell_cfg[i] = $urandom();
                cell_cfg[i][8] = 1'b0;
                cell_cfg[i][9] = 1'b0;
                cell_din[i] = $urandom();
                exp[i] = cell_cfg[i][perm[cell_din[i]]];
            end
            #0.5;
            check("R1/R2 permuted LUT, unclocked", cell_out, exp);
            step();
        end
    endtask

    task automatic t_adder();
        logic [8:0] s;
        int av [6] = '{0, 255, 100, 255, 170, 200};
        int bv [6] = '{0, 1, 27, 255, 85, 100};
        int sv [6] = '{0, 0, 1, 2, 3, 2};
        int ev [6] = '{0, 0, 0, 1, 1, 0};
        all_cfg(mk_cfg(sum_truth(), 1, 0, 0, 0));
        carry_sub = '1;
        cascade_sub = '0;
        for (int v = 0; v < 6; v++) begin
            logic cin;
            cin_sel = sv[v][1:0];
            cin_ext = ev[v][0];
            cin = (sv[v] == 1) ? 1'b1 : (sv[v] == 2) ? ev[v][0] : 1'b0;
            for (int i = 0; i < N; i++) cell_din[i] = {1'b0, bv[v][i], av[v][i], 1'b0};
            s = 9'(av[v]) + 9'(bv[v]) + 9'(cin);
            #0.5;
            check("R3/R4/R5 adder sum", cell_out, s[7:0]);
            check("R12 adder carry out", cout_top, s[8]);
            step();
        end
        // Carry disabled: each cell sees carry in 0 except cell 0 (constant 1).
        all_cfg(mk_cfg(sum_truth(), 0, 0, 0, 0));
        cin_sel = 2'd1;
        for (int i = 0; i < N; i++) cell_din[i] = 4'b0110;
        #0.5;
        check("R3 carry disabled outputs", cell_out, 8'h01);
        check("R3 carry disabled cout_top", cout_top, 0);
        step();
        carry_sub = '0;
        cin_sel = 2'd0;
        cin_ext = 1'b0;
    endtask

    task automatic t_in3_sub();
        all_cfg('0);
        cell_cfg[0] = mk_cfg(16'hFF00, 0, 0, 0, 0);
        carry_sub = 8'h01;
        cell_din = '0;
        cin_sel = 2'd1;
        #0.5; check("R5 in3 from constant-1 carry in", cell_out, 8'h01);
        cin_sel = 2'd2; cin_ext = 1'b1;
        #0.5; check("R4/R5 in3 from external carry high", cell_out, 8'h01);
        cin_ext = 1'b0;
        #0.5; check("R4/R5 in3 from external carry low", cell_out, 8'h00);
        carry_sub = '0; cin_sel = 2'd0; cell_din[0] = 4'b1000;
        #0.5; check("R5 in3 direct without substitution", cell_out, 8'h01);
        step();
        cell_din = '0;
    endtask

    task automatic t_cascade();
        all_cfg(mk_cfg(16'hF0F0, 0, 0, 0, 0));
        cell_cfg[0] = mk_cfg(16'hAAAA, 0, 0, 0, 0);
        cascade_sub = 8'hFE;
        cell_din = '0;
        cell_din[0] = 4'b0001;
        #0.5; check("R6 cascade buffer chain high", cell_out, 8'hFF);
        cell_din[0] = 4'b0000;
        #0.5; check("R6 cascade buffer chain low", cell_out, 8'h00);
        all_cfg(mk_cfg(16'h0F0F, 0, 0, 0, 0));
        cell_cfg[0] = mk_cfg(16'hF0F0, 0, 0, 0, 0);
        cascade_sub = 8'hFF;
        cell_din[0] = 4'b0100;
        #0.5; check("R6 cell 0 cascade select ignored, inverting chain", cell_out, 8'h55);
        step();
        cascade_sub = '0;
        cell_din = '0;
    endtask

    task automatic t_register();
        all_cfg(mk_cfg(16'hAAAA, 0, 1, 0, 0));
        ce = 1'b1;
        set_bit0(8'h3C);
        #0.5; check("R7 registered output waits for edge", cell_out, 8'h00);
        step();
        check("R7 load on edge with enable", cell_out, 8'h3C);
        ce = 1'b0;
        set_bit0(8'hC3);
        step();
        check("R7 hold without enable", cell_out, 8'h3C);
        ce = 1'b1;
        set_bit0(8'hFF);
        step();
        check("R7 reload", cell_out, 8'hFF);
        rst = 1'b1;
        step();
        check("R11 reset beats enable", cell_out, 8'h00);
        rst = 1'b0;
        ce = 1'b0;
    endtask

    task automatic t_sync_sr();
        for (int i = 0; i < N; i++) cell_cfg[i] = mk_cfg(16'hAAAA, 0, 1, (i % 2) == 0, 0);
        ce = 1'b1;
        set_bit0(8'hA5);
        step();
        check("R7 preload for sync set/reset", cell_out, 8'hA5);
        ce = 1'b0;
        sr = 1'b1;
        #0.5; check("R8 sync set/reset waits for edge", cell_out, 8'hA5);
        step();
        check("R8 sync set/reset per-cell value", cell_out, 8'h55);
        ce = 1'b1;
        set_bit0(8'hFF);
        step();
        check("R8 set/reset beats enable", cell_out, 8'h55);
        sr = 1'b0;
        ce = 1'b0;
        step();
    endtask

    task automatic t_async_sr();
        for (int i = 0; i < N; i++) cell_cfg[i] = mk_cfg(16'hAAAA, 0, 1, i < 4, 1);
        ce = 1'b1;
        set_bit0(8'hF0);
        step();
        check("R7 preload for async set/reset", cell_out, 8'hF0);
        ce = 1'b0;
        sr = 1'b1;
        #0.5; check("R9 async set/reset acts before edge", cell_out, 8'h0F);
        step();
        check("R9 async held while asserted", cell_out, 8'h0F);
        sr = 1'b0;
        step();
        check("R9 value kept after release", cell_out, 8'h0F);
    endtask

    task automatic t_neg_edge();
        all_cfg(mk_cfg(16'hAAAA, 0, 1, 0, 0));
        ce = 1'b0;
        neg_edge = 1'b1;
        step();
        ce = 1'b1;
        set_bit0(8'h96);
        #0.5; check("R10 no load before falling edge", cell_out, 8'h0F);
        @(negedge clk); #0.5;
        check("R10 load on falling edge", cell_out, 8'h96);
        set_bit0(8'h69);
        @(posedge clk); #0.5;
        check("R10 rising edge ignored", cell_out, 8'h96);
        @(negedge clk); #0.5;
        check("R10 second falling edge load", cell_out, 8'h69);
        @(posedge clk); #1;
        ce = 1'b0;
        neg_edge = 1'b0;
        step();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        errs++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        t_reset_state();
        t_lut_random();
        t_adder();
        t_in3_sub();
        t_cascade();
        t_register();
        t_sync_sr();
        t_async_sr();
        t_neg_edge();
        finish_run();
    end
endmodule